// File: doc/BRIEF.md
# Store Commit and Writeback Engine

This block holds the store half of a load-store queue once its stores have executed. Stores enter at the tail in program order. Each store carries a sequence number, an access size, a prefetch flag, an address and data. A commit input gives the youngest sequence number the machine has retired. Every store at or below that number becomes eligible to write back.

A writeback pointer, kept apart from the head, walks eligible stores in queue order and presents them to a data cache that has several request slots. The number of slots per cycle is bounded by a port budget. The walk halts while the cache reports blocked. A store the cache hits completes in its issue cycle. A store that misses completes later, when a completion response names its queue index.

Stores can therefore finish out of order, but entries are freed only as a contiguous run of completed stores starting at the head. The block also records one load that is waiting on a particular store. When that store is written or completes, the block releases the stall and asks for the load to be replayed.

Top module: `store_wb_engine`

## Requirements
- R1: On a cycle with `cmt_valid_i`, stores are examined from the head in queue order. Stores already eligible are passed over. Each not-yet-eligible store whose sequence number is unsigned-less-than-or-equal to `cmt_seq_i` becomes eligible. The examination stops at the first not-yet-eligible store whose sequence number is greater. The new eligibility is first used by writeback in the next cycle.
- R2: `pend_o` counts eligible stores that have not completed. It rises by the number of stores made eligible in a cycle and falls by the number that complete in that cycle, one cycle later.
- R3: Each cycle the writeback walk starts at the writeback pointer and goes in queue order. It stops at the tail, at a store that is not eligible, when the port budget `PORTS` is used up, or when the stores it has finished in that walk without a cache access reach `pend_o`. Cache writes take request slots 0, 1, ... in walk order. `dc_req_idx_o` and `dc_req_addr_o` give the store's queue slot and address. Requests are presented in the same cycle as the walk.
- R4: A store of size zero completes in the walk cycle. It takes no port and makes no request, and the walk continues past it.
- R5: While `dc_blocked_i` is high, no request is valid. The walk halts at the first store of nonzero size, but zero-size stores ahead of it still complete.
- R6: A prefetch store with nonzero size takes a request slot without raising that slot's valid bit. It completes in the walk cycle.
- R7: A written store whose slot sees `dc_hit_i` high in the issue cycle completes in that cycle. Otherwise it completes on the cycle when `cpl_valid_i` is high with `cpl_idx_i` equal to its queue slot. Each store is sent to the cache at most once.
- R8: `count_o` (occupancy) falls only by the length of the run of completed stores that begins at the head. A completion behind an incomplete head frees nothing until the head completes. A miss completion and new issues in the same cycle are both counted.
- R9: After `stall_set_i` records a store sequence number and a load index, `stalled_o` is high. In the first cycle in which a store with that sequence number is sent to the cache or completes, the stall clears next cycle, and `replay_valid_o` pulses for one cycle with `replay_lq_idx_o` equal to the recorded load index.
- R10: `stall_set_i` has no effect while `stalled_o` is high. The recorded load index and store number are kept.
- R11: A store is accepted at the tail when `alloc_valid_i` is high and `alloc_ready_o` is high. `alloc_ready_o` is high exactly when `count_o` is below `DEPTH`. A request while full is dropped.
- R12: After reset `count_o` and `pend_o` are 0, no request is valid, and `stalled_o` and `replay_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Store entry request |
| alloc_seq_i | input | SEQ_W | Store sequence number |
| alloc_size_i | input | SIZE_W | Access size, zero for a null store |
| alloc_pref_i | input | 1 | Prefetch store, no cache write |
| alloc_addr_i | input | ADDR_W | Store address |
| alloc_data_i | input | DATA_W | Store data |
| alloc_ready_o | output | 1 | Queue has a free entry |
| cmt_valid_i | input | 1 | Commit update valid |
| cmt_seq_i | input | SEQ_W | Youngest committed sequence number |
| dc_blocked_i | input | 1 | Cache cannot accept writes |
| dc_req_valid_o | output | PORTS | Write request per slot |
| dc_req_addr_o | output | PORTS x ADDR_W | Request address per slot |
| dc_req_data_o | output | PORTS x DATA_W | Request data per slot |
| dc_req_size_o | output | PORTS x SIZE_W | Request size per slot |
| dc_req_idx_o | output | PORTS x log2(DEPTH) | Queue slot of request |
| dc_hit_i | input | PORTS | Same-cycle hit per request slot |
| cpl_valid_i | input | 1 | Miss completion |
| cpl_idx_i | input | log2(DEPTH) | Queue slot of completed miss |
| stall_set_i | input | 1 | Record a stalled load |
| stall_seq_i | input | SEQ_W | Store the load waits for |
| stall_lq_idx_i | input | LQ_IDX_W | Load queue index of waiting load |
| stalled_o | output | 1 | A stall is recorded |
| replay_valid_o | output | 1 | Replay pulse for the waiting load |
| replay_lq_idx_o | output | LQ_IDX_W | Load index to replay |
| count_o | output | log2(DEPTH)+1 | Occupied entries |
| pend_o | output | log2(DEPTH)+1 | Eligible, not yet completed stores |

## Verification
The bench targets several ordering cases:
- Misses that complete younger-first. A design that freed on any completion would drop the count too early.
- A blocked cache with zero-size stores ahead of a real store. Stalling those null stores would freeze the head.
- A prefetch sharing a cycle with a real write. Forgetting the consumed slot would put the write on the wrong request slot.
- A commit whose number falls inside the queue, and a second stall record while one is live. A design that overwrote the first record would replay the wrong load.
- Long mixed traffic that puts completions, issues, commits and allocations into the same cycle, with the queue full.

// File: rtl/sq_wb_pkg.sv
package sq_wb_pkg;
  typedef enum logic [1:0] {
    STEP_HALT  = 2'd0,
    STEP_ZERO  = 2'd1,
    STEP_PREF  = 2'd2,
    STEP_WRITE = 2'd3
  } wb_step_e;
endpackage

// File: rtl/sq_commit_walk.sv
module sq_commit_walk #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             en_i,
  input  logic [SEQ_W-1:0] cmt_seq_i,
  input  logic [IDX_W-1:0] head_i,
  input  logic [CNT_W-1:0] occ_i,
  input  logic [DEPTH-1:0] elig_i,
  input  logic [SEQ_W-1:0] seq_i [DEPTH],
  output logic [DEPTH-1:0] mark_o
);
  logic             go;
  logic [IDX_W-1:0] idx;

  always_comb begin
    go     = en_i;
    mark_o = '0;
    idx    = head_i;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_i + IDX_W'(k);
      if (go && (CNT_W'(k) < occ_i) && !elig_i[idx]) begin
        if (seq_i[idx] > cmt_seq_i) go = 1'b0;
        else mark_o[idx] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sq_wb_issue.sv
module sq_wb_issue import sq_wb_pkg::*; #(
  parameter int DEPTH  = 8,
  parameter int PORTS  = 2,
  parameter int SIZE_W = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              [IDX_W-1:0]  wb_i,
  input  logic              [CNT_W-1:0]  left_i,
  input  logic              [CNT_W-1:0]  pend_i,
  input  logic                           blocked_i,
  input  logic              [DEPTH-1:0]  elig_i,
  input  logic              [DEPTH-1:0]  pref_i,
  input  logic              [SIZE_W-1:0] size_i [DEPTH],
  output logic [PORTS-1:0]               req_valid_o,
  output logic [PORTS-1:0]  [IDX_W-1:0]  req_idx_o,
  output logic              [DEPTH-1:0]  issue_o,
  output logic              [DEPTH-1:0]  quick_o,
  output logic              [CNT_W-1:0]  steps_o
);
  logic             go;
  int               used;
  int               qd;
  logic [IDX_W-1:0] idx;
  wb_step_e         kind;

  always_comb begin
    go          = 1'b1;
    used        = 0;
    qd          = 0;
    req_valid_o = '0;
    req_idx_o   = '0;
    issue_o     = '0;
    quick_o     = '0;
    steps_o     = '0;
    idx         = wb_i;
    kind        = STEP_HALT;
    for (int k = 0; k < DEPTH; k++) begin
      idx  = wb_i + IDX_W'(k);
      kind = STEP_HALT;
      if (go && (CNT_W'(k) < left_i) && elig_i[idx] && (used < PORTS) &&
          (CNT_W'(qd) < pend_i)) begin
        if (size_i[idx] == '0)  kind = STEP_ZERO;
        else if (!blocked_i)    kind = pref_i[idx] ? STEP_PREF : STEP_WRITE;
      end
      case (kind)
        STEP_ZERO: begin
          quick_o[idx] = 1'b1;
          qd           = qd + 1;
          steps_o      = steps_o + CNT_W'(1);
        end
        STEP_PREF: begin
          quick_o[idx] = 1'b1;
          qd           = qd + 1;
          used         = used + 1;
          steps_o      = steps_o + CNT_W'(1);
        end
        STEP_WRITE: begin
          for (int p = 0; p < PORTS; p++) begin
            if (p == used) begin
              req_valid_o[p] = 1'b1;
              req_idx_o[p]   = idx;
            end
          end
          issue_o[idx] = 1'b1;
          used         = used + 1;
          steps_o      = steps_o + CNT_W'(1);
        end
        default: go = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/sq_head_retire.sv
module sq_head_retire #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic [IDX_W-1:0] head_i,
  input  logic [CNT_W-1:0] occ_i,
  input  logic [DEPTH-1:0] cmp_i,
  output logic [DEPTH-1:0] free_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             run;
  logic [IDX_W-1:0] idx;

  always_comb begin
    run    = 1'b1;
    free_o = '0;
    cnt_o  = '0;
    idx    = head_i;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_i + IDX_W'(k);
      if (run && (CNT_W'(k) < occ_i) && cmp_i[idx]) begin
        free_o[idx] = 1'b1;
        cnt_o       = cnt_o + CNT_W'(1);
      end else begin
        run = 1'b0;
      end
    end
  end
endmodule

// File: rtl/store_wb_engine.sv
module store_wb_engine import sq_wb_pkg::*; #(
  parameter int DEPTH    = 8,
  parameter int PORTS    = 2,
  parameter int SEQ_W    = 16,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int SIZE_W   = 4,
  parameter int LQ_IDX_W = 4,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int CNT_W   = IDX_W + 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            alloc_valid_i,
  input  logic [SEQ_W-1:0]                alloc_seq_i,
  input  logic [SIZE_W-1:0]               alloc_size_i,
  input  logic                            alloc_pref_i,
  input  logic [ADDR_W-1:0]               alloc_addr_i,
  input  logic [DATA_W-1:0]               alloc_data_i,
  output logic                            alloc_ready_o,
  input  logic                            cmt_valid_i,
  input  logic [SEQ_W-1:0]                cmt_seq_i,
  input  logic                            dc_blocked_i,
  output logic [PORTS-1:0]                dc_req_valid_o,
  output logic [PORTS-1:0][ADDR_W-1:0]    dc_req_addr_o,
  output logic [PORTS-1:0][DATA_W-1:0]    dc_req_data_o,
  output logic [PORTS-1:0][SIZE_W-1:0]    dc_req_size_o,
  output logic [PORTS-1:0][IDX_W-1:0]     dc_req_idx_o,
  input  logic [PORTS-1:0]                dc_hit_i,
  input  logic                            cpl_valid_i,
  input  logic [IDX_W-1:0]                cpl_idx_i,
  input  logic                            stall_set_i,
  input  logic [SEQ_W-1:0]                stall_seq_i,
  input  logic [LQ_IDX_W-1:0]             stall_lq_idx_i,
  output logic                            stalled_o,
  output logic                            replay_valid_o,
  output logic [LQ_IDX_W-1:0]             replay_lq_idx_o,
  output logic [CNT_W-1:0]                count_o,
  output logic [CNT_W-1:0]                pend_o
);
  // entry payload
  logic [SEQ_W-1:0]  seq_q  [DEPTH];
  logic [SIZE_W-1:0] size_q [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  pref_q;

  // entry flags: eligible, sent to cache, completed
  logic [DEPTH-1:0]  elig_q, iss_q, done_q;
  logic [DEPTH-1:0]  elig_d, iss_d, done_d;

  // pointers carry a wrap bit
  logic [CNT_W-1:0]  head_q, tail_q, wb_q, pend_q;
  logic [CNT_W-1:0]  occ, wb_left, pend_d;
  logic [IDX_W-1:0]  head_idx, tail_idx, wb_idx;

  logic              stall_q, replay_q;
  logic [SEQ_W-1:0]  stall_seq_q;
  logic [LQ_IDX_W-1:0] stall_lq_q, replay_idx_q;

  logic [DEPTH-1:0]  mark, issue_v, quick_v, hit_v, cpl_v, done_now, cmp_next, free_v;
  logic [PORTS-1:0]  req_v;
  logic [PORTS-1:0][IDX_W-1:0] req_idx;
  logic [CNT_W-1:0]  steps, free_cnt;
  logic              do_alloc, rel;

  assign occ      = tail_q - head_q;
  assign wb_left  = tail_q - wb_q;
  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign wb_idx   = wb_q[IDX_W-1:0];
  assign do_alloc = alloc_valid_i && (occ != CNT_W'(DEPTH));

  sq_commit_walk #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_cmt (
    .en_i      (cmt_valid_i),
    .cmt_seq_i (cmt_seq_i),
    .head_i    (head_idx),
    .occ_i     (occ),
    .elig_i    (elig_q),
    .seq_i     (seq_q),
    .mark_o    (mark)
  );

  sq_wb_issue #(.DEPTH(DEPTH), .PORTS(PORTS), .SIZE_W(SIZE_W)) u_wb (
    .wb_i        (wb_idx),
    .left_i      (wb_left),
    .pend_i      (pend_q),
    .blocked_i   (dc_blocked_i),
    .elig_i      (elig_q),
    .pref_i      (pref_q),
    .size_i      (size_q),
    .req_valid_o (req_v),
    .req_idx_o   (req_idx),
    .issue_o     (issue_v),
    .quick_o     (quick_v),
    .steps_o     (steps)
  );

  // same-cycle hits per request slot
  always_comb begin
    hit_v = '0;
    for (int p = 0; p < PORTS; p++)
      if (req_v[p] && dc_hit_i[p]) hit_v[req_idx[p]] = 1'b1;
  end

  // miss completion only for entries waiting on the cache
  always_comb begin
    cpl_v = '0;
    if (cpl_valid_i) cpl_v[cpl_idx_i] = iss_q[cpl_idx_i] & ~done_q[cpl_idx_i];
  end

  assign done_now = quick_v | hit_v | cpl_v;
  assign cmp_next = done_q | done_now;

  sq_head_retire #(.DEPTH(DEPTH)) u_ret (
    .head_i (head_idx),
    .occ_i  (occ),
    .cmp_i  (cmp_next),
    .free_o (free_v),
    .cnt_o  (free_cnt)
  );

  generate
    for (genvar p = 0; p < PORTS; p++) begin : g_port
      assign dc_req_addr_o[p] = addr_q[req_idx[p]];
      assign dc_req_data_o[p] = data_q[req_idx[p]];
      assign dc_req_size_o[p] = size_q[req_idx[p]];
    end
  endgenerate
  assign dc_req_valid_o = req_v;
  assign dc_req_idx_o   = req_idx;

  always_comb begin
    rel = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (stall_q && (issue_v[i] || done_now[i]) && (seq_q[i] == stall_seq_q)) rel = 1'b1;
  end

  always_comb begin
    elig_d = (elig_q | mark) & ~free_v;
    iss_d  = (iss_q | issue_v) & ~free_v;
    done_d = cmp_next & ~free_v;
    if (do_alloc) begin
      elig_d[tail_idx] = 1'b0;
      iss_d[tail_idx]  = 1'b0;
      done_d[tail_idx] = 1'b0;
    end
    pend_d = pend_q + CNT_W'($countones(mark)) - CNT_W'($countones(done_now));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q       <= '0;
      tail_q       <= '0;
      wb_q         <= '0;
      pend_q       <= '0;
      elig_q       <= '0;
      iss_q        <= '0;
      done_q       <= '0;
      stall_q      <= 1'b0;
      stall_seq_q  <= '0;
      stall_lq_q   <= '0;
      replay_q     <= 1'b0;
      replay_idx_q <= '0;
    end else begin
      head_q   <= head_q + free_cnt;
      tail_q   <= tail_q + CNT_W'(do_alloc);
      wb_q     <= wb_q + steps;
      pend_q   <= pend_d;
      elig_q   <= elig_d;
      iss_q    <= iss_d;
      done_q   <= done_d;
      replay_q <= rel;
      if (rel) begin
        replay_idx_q <= stall_lq_q;
        stall_q      <= 1'b0;
      end else if (!stall_q && stall_set_i) begin
        stall_q     <= 1'b1;
        stall_seq_q <= stall_seq_i;
        stall_lq_q  <= stall_lq_idx_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_alloc) begin
      seq_q[tail_idx]  <= alloc_seq_i;
      size_q[tail_idx] <= alloc_size_i;
      addr_q[tail_idx] <= alloc_addr_i;
      data_q[tail_idx] <= alloc_data_i;
      pref_q[tail_idx] <= alloc_pref_i;
    end
  end

  assign alloc_ready_o   = (occ != CNT_W'(DEPTH));
  assign count_o         = occ;
  assign pend_o          = pend_q;
  assign stalled_o       = stall_q;
  assign replay_valid_o  = replay_q;
  assign replay_lq_idx_o = replay_idx_q;

  // assertions
  assert_occ_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= CNT_W'(DEPTH));
  assert_pend_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= occ);
  assert_wb_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_q - head_q) <= occ);
  assert_blocked_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dc_blocked_i |-> (dc_req_valid_o == '0));
  assert_no_reissue_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_v & iss_q) == '0);
  assert_cpl_target_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_i |-> (iss_q[cpl_idx_i] && !done_q[cpl_idx_i]));
  assert_replay_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_valid_o |=> !replay_valid_o);
  assert_head_frees_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_cnt != '0) |-> cmp_next[head_idx]);
  generate
    for (genvar p = 0; p < PORTS; p++) begin : g_req_chk
      assert_req_elig_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dc_req_valid_o[p] |-> elig_q[dc_req_idx_o[p]]);
    end
  endgenerate
endmodule

// File: tb/store_wb_engine_tb_top.sv
`timescale 1ns/1ps
module store_wb_engine_tb_top;
  localparam int DEPTH = 8;
  localparam int PORTS = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic        alloc_valid_i = 0;
  logic [15:0] alloc_seq_i = 0;
  logic [3:0]  alloc_size_i = 0;
  logic        alloc_pref_i = 0;
  logic [31:0] alloc_addr_i = 0;
  logic [63:0] alloc_data_i = 0;
  logic        alloc_ready_o;
  logic        cmt_valid_i = 0;
  logic [15:0] cmt_seq_i = 0;
  logic        dc_blocked_i = 0;
  logic [PORTS-1:0]        dc_req_valid_o;
  logic [PORTS-1:0][31:0]  dc_req_addr_o;
  logic [PORTS-1:0][63:0]  dc_req_data_o;
  logic [PORTS-1:0][3:0]   dc_req_size_o;
  logic [PORTS-1:0][2:0]   dc_req_idx_o;
  logic [PORTS-1:0]        dc_hit_i = 0;
  logic        cpl_valid_i = 0;
  logic [2:0]  cpl_idx_i = 0;
  logic        stall_set_i = 0;
  logic [15:0] stall_seq_i = 0;
  logic [3:0]  stall_lq_idx_i = 0;
  logic        stalled_o, replay_valid_o;
  logic [3:0]  replay_lq_idx_o;
  logic [3:0]  count_o, pend_o;

  store_wb_engine dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_valid_i, .alloc_seq_i, .alloc_size_i, .alloc_pref_i, .alloc_addr_i, .alloc_data_i,
    .alloc_ready_o, .cmt_valid_i, .cmt_seq_i, .dc_blocked_i,
    .dc_req_valid_o, .dc_req_addr_o, .dc_req_data_o, .dc_req_size_o, .dc_req_idx_o,
    .dc_hit_i, .cpl_valid_i, .cpl_idx_i, .stall_set_i, .stall_seq_i, .stall_lq_idx_i,
    .stalled_o, .replay_valid_o, .replay_lq_idx_o, .count_o, .pend_o
  );

  int n_checks = 0;
  int n_fail = 0;
  string cur_tag = "R12";
  bit finished = 0;

  // behavioural model state
  int m_seq [DEPTH];
  int m_size[DEPTH];
  int m_addr[DEPTH];
  bit m_pref[DEPTH], m_elig[DEPTH], m_iss[DEPTH], m_done[DEPTH];
  int m_head = 0, m_occ = 0, m_wbo = 0, m_pend = 0;
  bit m_stall = 0, m_rep = 0;
  int m_sseq = 0, m_slq = 0, m_repidx = 0;
  int next_seq = 100;

  task automatic chk(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_tag, what, act, exp);
    end
  endtask

  task automatic cyc();
    bit mark[DEPTH]; bit dn[DEPTH]; bit isn[DEPTH];
    bit ev[PORTS]; int ei[PORTS];
    int used, dc, steps, tail, occ0, nm, nd;
    bit go, rel;
    foreach (mark[i]) begin mark[i] = 0; dn[i] = 0; isn[i] = 0; end
    foreach (ev[p]) begin ev[p] = 0; ei[p] = 0; end
    #1;
    // commit walk
    if (cmt_valid_i) begin
      for (int k = 0; k < m_occ; k++) begin
        int i;
        i = (m_head + k) % DEPTH;
        if (!m_elig[i]) begin
          if (m_seq[i] > int'(cmt_seq_i)) break;
          mark[i] = 1;
        end
      end
    end
    // writeback walk
    used = 0; dc = 0; steps = 0; go = 1;
    for (int k = 0; k < DEPTH; k++) begin
      int i;
      if (k >= m_occ - m_wbo) break;
      i = (m_head + m_wbo + k) % DEPTH;
      if (!m_elig[i] || used >= PORTS || dc >= m_pend) break;
      if (m_size[i] == 0) begin dn[i] = 1; dc++; steps++; continue; end
      if (dc_blocked_i) break;
      if (m_pref[i]) begin dn[i] = 1; dc++; used++; steps++; end
      else begin
        ev[used] = 1; ei[used] = i; isn[i] = 1;
        if (dc_hit_i[used]) dn[i] = 1;
        used++; steps++;
      end
    end
    if (cpl_valid_i) dn[cpl_idx_i] = 1;
    rel = 0;
    for (int i = 0; i < DEPTH; i++)
      if (m_stall && (isn[i] || dn[i]) && m_seq[i] == m_sseq) rel = 1;
    // compare
    chk("count", int'(count_o), m_occ);
    chk("pend", int'(pend_o), m_pend);
    chk("stalled", int'(stalled_o), int'(m_stall));
    chk("replay_valid", int'(replay_valid_o), int'(m_rep));
    if (m_rep) chk("replay_idx", int'(replay_lq_idx_o), m_repidx);
    chk("alloc_ready", int'(alloc_ready_o), int'(m_occ < DEPTH));
    for (int p = 0; p < PORTS; p++) begin
      chk("req_valid", int'(dc_req_valid_o[p]), int'(ev[p]));
      if (ev[p]) begin
        chk("req_idx", int'(dc_req_idx_o[p]), ei[p]);
        chk("req_addr", int'(dc_req_addr_o[p]), m_addr[ei[p]]);
      end
    end
    @(posedge clk);
    tail = (m_head + m_occ) % DEPTH;
    occ0 = m_occ;
    nm = 0; nd = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (mark[i]) begin m_elig[i] = 1; nm++; end
      if (isn[i]) m_iss[i] = 1;
      if (dn[i]) begin m_done[i] = 1; nd++; end
    end
    m_pend = m_pend + nm - nd;
    m_wbo = m_wbo + steps;
    while (m_occ > 0 && m_done[m_head]) begin
      m_elig[m_head] = 0; m_iss[m_head] = 0; m_done[m_head] = 0;
      m_head = (m_head + 1) % DEPTH; m_occ--; m_wbo--;
    end
    if (alloc_valid_i && occ0 < DEPTH) begin
      m_seq[tail] = int'(alloc_seq_i); m_size[tail] = int'(alloc_size_i);
      m_addr[tail] = int'(alloc_addr_i); m_pref[tail] = alloc_pref_i;
      m_elig[tail] = 0; m_iss[tail] = 0; m_done[tail] = 0;
      m_occ++;
    end
    m_rep = rel;
    if (rel) begin m_repidx = m_slq; m_stall = 0; end
    else if (!m_stall && stall_set_i) begin
      m_stall = 1; m_sseq = int'(stall_seq_i); m_slq = int'(stall_lq_idx_i);
    end
    @(negedge clk);
    alloc_valid_i = 0; cmt_valid_i = 0; dc_blocked_i = 0; dc_hit_i = '0;
    cpl_valid_i = 0; stall_set_i = 0;
  endtask

  task automatic set_alloc(int sz, bit pf);
    alloc_valid_i = 1; alloc_seq_i = 16'(next_seq); alloc_size_i = 4'(sz);
    alloc_pref_i = pf; alloc_addr_i = 32'(32'h1000 + next_seq * 16);
    alloc_data_i = 64'(next_seq);
    next_seq++;
  endtask

  task automatic put(int sz, bit pf);
    set_alloc(sz, pf); cyc();
  endtask

  task automatic commit_upto(int s);
    cmt_valid_i = 1; cmt_seq_i = 16'(s); cyc();
  endtask

  task automatic idle(int n);
    for (int j = 0; j < n; j++) cyc();
  endtask

  // pick an outstanding miss: first (oldest) or last in queue order
  function automatic int find_miss(bit oldest);
    int r;
    r = -1;
    for (int k = 0; k < m_occ; k++) begin
      int i;
      i = (m_head + k) % DEPTH;
      if (m_iss[i] && !m_done[i]) begin
        r = i;
        if (oldest) break;
      end
    end
    return r;
  endfunction

  task automatic complete(bit oldest);
    int i;
    i = find_miss(oldest);
    if (i >= 0) begin cpl_valid_i = 1; cpl_idx_i = 3'(i); end
    cyc();
  endtask

  task automatic drain();
    for (int j = 0; j < 40 && m_occ > 0; j++) begin
      cmt_valid_i = 1; cmt_seq_i = 16'(next_seq);
      dc_hit_i = '1;
      if (find_miss(1) >= 0) begin cpl_valid_i = 1; cpl_idx_i = 3'(find_miss(1)); end
      cyc();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    cur_tag = "R12";
    chk("count", int'(count_o), 0);
    chk("pend", int'(pend_o), 0);
    chk("req_valid", int'(dc_req_valid_o), 0);
    chk("stalled", int'(stalled_o), 0);
    chk("replay_valid", int'(replay_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1/R2: partial commit inside the queue
    cur_tag = "R1";
    for (int j = 0; j < 4; j++) put(8, 0);
    commit_upto(101);
    cur_tag = "R2";
    chk("pend_after_commit", int'(pend_o), 2);
    // R3/R7: two writes in one cycle, both hit
    cur_tag = "R3";
    dc_hit_i = 2'b11; cyc();
    chk("count_after_hits", int'(count_o), 2);
    commit_upto(103);
    cur_tag = "R7";
    dc_hit_i = 2'b00; cyc();           // both miss
    complete(0);                        // younger first
    cur_tag = "R8";
    chk("no_free_behind_head", int'(count_o), 2);
    complete(1);
    chk("head_run_frees", int'(count_o), 0);

    // R4: zero-size stores complete without ports
    cur_tag = "R4";
    put(0, 0); put(0, 0); put(0, 0); put(4, 0);
    commit_upto(next_seq - 1);
    dc_hit_i = 2'b11; cyc();
    idle(2);

    // R5: blocked cache with zero-size ahead
    cur_tag = "R5";
    put(0, 0); put(8, 0); put(8, 0);
    commit_upto(next_seq - 1);
    dc_blocked_i = 1; cyc();
    dc_blocked_i = 1; cyc();
    dc_hit_i = 2'b01; cyc();
    dc_hit_i = 2'b11; cyc();
    idle(2);

    // R6: prefetch takes slot 0, write goes to slot 1
    cur_tag = "R6";
    put(8, 1); put(8, 0); put(8, 1);
    commit_upto(next_seq - 1);
    dc_hit_i = 2'b10; cyc();
    idle(2);

    // R9/R10: stall on a missing store, second record ignored
    cur_tag = "R9";
    put(8, 0); put(8, 0);
    stall_set_i = 1; stall_seq_i = 16'(next_seq - 1); stall_lq_idx_i = 4'd9; cyc();
    cur_tag = "R10";
    stall_set_i = 1; stall_seq_i = 16'(next_seq - 2); stall_lq_idx_i = 4'd3; cyc();
    commit_upto(next_seq - 1);
    cyc();                              // both issued as misses
    complete(1);
    cur_tag = "R9";
    cyc();
    complete(1);
    idle(2);

    // R11: fill to full, extra request dropped
    cur_tag = "R11";
    for (int j = 0; j < DEPTH + 2; j++) put(8, 0);
    chk("full_count", int'(count_o), DEPTH);
    drain();

    // mixed traffic
    cur_tag = "R8";
    for (int n = 0; n < 800; n++) begin
      if ($urandom_range(0, 2) != 0) set_alloc(($urandom_range(0, 4) == 0) ? 0 : 8,
                                               ($urandom_range(0, 7) == 0));
      if ($urandom_range(0, 2) == 0) begin
        cmt_valid_i = 1; cmt_seq_i = 16'($urandom_range(100, next_seq));
      end
      dc_blocked_i = ($urandom_range(0, 4) == 0);
      dc_hit_i = 2'($urandom_range(0, 3));
      if (find_miss(0) >= 0 && $urandom_range(0, 1) == 1) begin
        int c;
        c = find_miss($urandom_range(0, 1) == 1);
        cpl_valid_i = 1; cpl_idx_i = 3'(c);
      end
      if (!m_stall && m_occ > 0 && $urandom_range(0, 5) == 0) begin
        int s;
        s = (m_head + $urandom_range(0, m_occ - 1)) % DEPTH;
        if (!m_done[s]) begin
          stall_set_i = 1; stall_seq_i = 16'(m_seq[s]);
          stall_lq_idx_i = 4'($urandom_range(0, 15));
        end
      end
      cyc();
    end
    drain();
    idle(2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule